// File: doc/BRIEF.md
# Cache Data Slice with Spare Sub-Block

This block is one bit-slice of the data array of a direct-mapped first-level cache. It stores 32 rows of 64 bits. The rows are split across eight 8-bit-wide sub-blocks, and a ninth identical sub-block is held in reserve. Eight such slices side by side make the full cache. Each slice keeps 4 bits of every 32-bit cache word, so one row across the eight slices is a 512-bit cache block.

There are two access paths. The refill path moves a whole 64-bit row into or out of the slice in one cycle, which is how a complete block passes to or from the next cache level. The processor path reads or writes a single 4-bit nibble of a row. The nibble is chosen by the low address bits.

A static 3-bit select input retires one of the eight sub-blocks. All write traffic to that sub-block goes into the spare, and all reads of its bits come from the spare. This lets a slice with one defective sub-block still work. The select comes straight from fixed pin levels: there is no configuration register and no load sequence.

Top module: `cache_slice_spare`

## Requirements
- R1: A refill write (`fill_we`=1) stores all 64 bits of `fill_wdata` into row `fill_row` at the clock edge.
- R2: `fill_rdata` shows the row that `fill_row` addressed at the previous clock edge (one registered cycle). If that row was written at the same edge, the old contents are returned.
- R3: `cpu_addr[8:4]` is the row and `cpu_addr[3:0]` is the nibble index n. `cpu_rdata` equals row bits [4n+3:4n] of the row addressed at the previous clock edge.
- R4: A processor write (`cpu_we`=1) changes only nibble n of the addressed row. The other 60 bits of that row keep their values.
- R5: If a refill write and a processor write target the same row in the same cycle, only the refill data is stored and the processor write is dropped. If they target different rows, both take effect.
- R6: With `spare_sel`=k (0..7), sub-block k holds row bits [8k+7:8k] (nibbles 2k and 2k+1). All reads and writes of those bits use the spare sub-block instead. Stored data reads back correctly for every k, even when sub-block k contains corrupt contents.
- R7: While sub-block k is retired it is never written, so its earlier contents survive. After `spare_sel` moves to j, bits of sub-block j read the spare's contents and the bits of k read sub-block k again. No data is moved by the switch.
- R8: A synchronous active-high `rst` clears `fill_rdata` and `cpu_rdata` to zero. It does not alter the stored rows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the read registers |
| spare_sel | input | 3 | Static index of the retired sub-block |
| fill_row | input | 5 | Row address of the refill path |
| fill_we | input | 1 | Refill write enable |
| fill_wdata | input | 64 | Full-row write data |
| fill_rdata | output | 64 | Full-row read data, one cycle after the address |
| cpu_addr | input | 9 | Processor address: row in [8:4], nibble in [3:0] |
| cpu_we | input | 1 | Processor nibble write enable |
| cpu_wdata | input | 4 | Processor nibble write data |
| cpu_rdata | output | 4 | Processor nibble read data, one cycle after the address |

## Verification
For each of the eight select values, the bench first loads garbage into the sub-block that is about to be retired. It then rewrites and reads back every row. A design that steered any read lane to the wrong physical block would return that garbage, and a design that failed to steer writes would return stale spare data. The bench then moves the select. This exposes a design that wrote into the retired block, or that copied data on the switch: the predicted garbage and spare contents would not appear where expected. Further directed cases cover same-cycle refill and processor writes to one row, where a design that let the processor win would show the wrong nibble. They also cover reading a row as it is written, where a write-first design would return the new value, and reset in the middle of a run, which must clear the outputs but keep the rows.

// File: rtl/cs_pkg.sv
package cs_pkg;
  localparam int CS_ROWS  = 32;
  localparam int CS_SUB_W = 8;
  localparam int CS_NSUB  = 8;
  localparam int CS_NIB_W = 4;

  // physical block that carries logical sub-block lg when sel is retired
  function automatic int phys_of(input int lg, input int sel, input int nsub);
    return (lg == sel) ? nsub : lg;
  endfunction
endpackage

// File: rtl/cs_subblock.sv
module cs_subblock #(
  parameter int ROWS  = 32,
  parameter int SUB_W = 8,
  parameter int NIB_W = 4,
  localparam int RA_W = $clog2(ROWS),
  localparam int NPS  = SUB_W / NIB_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RA_W-1:0]  a_row,
  input  logic             a_we,
  input  logic [SUB_W-1:0] a_din,
  input  logic [RA_W-1:0]  b_row,
  input  logic [NPS-1:0]   b_we,
  input  logic [SUB_W-1:0] b_din,
  output logic [SUB_W-1:0] a_q,
  output logic [SUB_W-1:0] b_q
);
  logic [SUB_W-1:0] mem [ROWS];

  // two write ports; same-row conflicts are removed upstream
  always_ff @(posedge clk) begin
    if (a_we) mem[a_row] <= a_din;
    for (int j = 0; j < NPS; j++) begin
      if (b_we[j]) mem[b_row][j*NIB_W +: NIB_W] <= b_din[j*NIB_W +: NIB_W];
    end
  end

  // registered read-first outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      a_q <= mem[a_row];
      b_q <= mem[b_row];
    end
  end
endmodule

// File: rtl/cs_wr_steer.sv
module cs_wr_steer #(
  parameter int ROWS  = 32,
  parameter int SUB_W = 8,
  parameter int NSUB  = 8,
  parameter int NIB_W = 4,
  localparam int RA_W  = $clog2(ROWS),
  localparam int ROW_W = SUB_W * NSUB,
  localparam int NPS   = SUB_W / NIB_W,
  localparam int NNIB  = ROW_W / NIB_W,
  localparam int NA_W  = $clog2(NNIB),
  localparam int SEL_W = $clog2(NSUB),
  localparam int HB_W  = $clog2(NPS),
  localparam int NPHYS = NSUB + 1
) (
  input  logic [SEL_W-1:0]                 spare_sel,
  input  logic                             fill_we,
  input  logic [RA_W-1:0]                  fill_row,
  input  logic [ROW_W-1:0]                 fill_wdata,
  input  logic                             cpu_we,
  input  logic [RA_W+NA_W-1:0]             cpu_addr,
  input  logic [NIB_W-1:0]                 cpu_wdata,
  output logic [NPHYS-1:0]                 a_we,
  output logic [NPHYS-1:0][SUB_W-1:0]      a_din,
  output logic [NPHYS-1:0][NPS-1:0]        b_we,
  output logic [SUB_W-1:0]                 b_din
);
  logic [NA_W-1:0]  cpu_nib;
  logic [RA_W-1:0]  cpu_row;
  logic [SEL_W-1:0] cpu_blk;
  logic [HB_W-1:0]  cpu_half;
  logic             cpu_go;
  logic [SUB_W-1:0] spare_din;

  assign cpu_nib  = cpu_addr[NA_W-1:0];
  assign cpu_row  = cpu_addr[NA_W +: RA_W];
  assign cpu_blk  = cpu_nib[NA_W-1 -: SEL_W];
  assign cpu_half = cpu_nib[HB_W-1:0];
  // refill has priority over a processor write to the same row
  assign cpu_go   = cpu_we && !(fill_we && (fill_row == cpu_row));
  assign b_din    = {NPS{cpu_wdata}};

  always_comb begin
    spare_din = '0;
    for (int l = 0; l < NSUB; l++) begin
      if (spare_sel == SEL_W'(l)) spare_din = fill_wdata[l*SUB_W +: SUB_W];
    end
  end

  for (genvar p = 0; p < NPHYS; p++) begin : g_phys
    if (p < NSUB) begin : g_main
      logic live;
      assign live     = (spare_sel != SEL_W'(p));
      assign a_we[p]  = fill_we && live;
      assign a_din[p] = fill_wdata[p*SUB_W +: SUB_W];
      for (genvar j = 0; j < NPS; j++) begin : g_lane
        assign b_we[p][j] = cpu_go && live && (cpu_blk == SEL_W'(p)) &&
                            (cpu_half == HB_W'(j));
      end
    end else begin : g_spare
      assign a_we[p]  = fill_we;
      assign a_din[p] = spare_din;
      for (genvar j = 0; j < NPS; j++) begin : g_lane
        assign b_we[p][j] = cpu_go && (cpu_blk == spare_sel) &&
                            (cpu_half == HB_W'(j));
      end
    end
  end
endmodule

// File: rtl/cs_rd_steer.sv
module cs_rd_steer #(
  parameter int SUB_W = 8,
  parameter int NSUB  = 8,
  parameter int NIB_W = 4,
  localparam int ROW_W = SUB_W * NSUB,
  localparam int NNIB  = ROW_W / NIB_W,
  localparam int NA_W  = $clog2(NNIB),
  localparam int SEL_W = $clog2(NSUB),
  localparam int NPHYS = NSUB + 1
) (
  input  logic [SEL_W-1:0]            sel_q,
  input  logic [NA_W-1:0]             nib_q,
  input  logic [NPHYS-1:0][SUB_W-1:0] a_q,
  input  logic [NPHYS-1:0][SUB_W-1:0] b_q,
  output logic [ROW_W-1:0]            fill_rdata,
  output logic [NIB_W-1:0]            cpu_rdata
);
  logic [ROW_W-1:0] cpu_row_data;

  for (genvar l = 0; l < NSUB; l++) begin : g_lane
    assign fill_rdata[l*SUB_W +: SUB_W]   = (sel_q == SEL_W'(l)) ? a_q[NSUB] : a_q[l];
    assign cpu_row_data[l*SUB_W +: SUB_W] = (sel_q == SEL_W'(l)) ? b_q[NSUB] : b_q[l];
  end

  always_comb begin
    cpu_rdata = '0;
    for (int n = 0; n < NNIB; n++) begin
      if (nib_q == NA_W'(n)) cpu_rdata = cpu_row_data[n*NIB_W +: NIB_W];
    end
  end
endmodule

// File: rtl/cache_slice_spare.sv
module cache_slice_spare import cs_pkg::*; #(
  parameter int ROWS  = CS_ROWS,
  parameter int SUB_W = CS_SUB_W,
  parameter int NSUB  = CS_NSUB,
  parameter int NIB_W = CS_NIB_W,
  localparam int RA_W  = $clog2(ROWS),
  localparam int ROW_W = SUB_W * NSUB,
  localparam int NPS   = SUB_W / NIB_W,
  localparam int NNIB  = ROW_W / NIB_W,
  localparam int NA_W  = $clog2(NNIB),
  localparam int SEL_W = $clog2(NSUB),
  localparam int NPHYS = NSUB + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [SEL_W-1:0]     spare_sel,
  input  logic [RA_W-1:0]      fill_row,
  input  logic                 fill_we,
  input  logic [ROW_W-1:0]     fill_wdata,
  output logic [ROW_W-1:0]     fill_rdata,
  input  logic [RA_W+NA_W-1:0] cpu_addr,
  input  logic                 cpu_we,
  input  logic [NIB_W-1:0]     cpu_wdata,
  output logic [NIB_W-1:0]     cpu_rdata
);
  logic [NPHYS-1:0]            a_we;
  logic [NPHYS-1:0][SUB_W-1:0] a_din;
  logic [NPHYS-1:0][SUB_W-1:0] a_q;
  logic [NPHYS-1:0][SUB_W-1:0] b_q;
  logic [NPHYS-1:0][NPS-1:0]   b_we;
  logic [SUB_W-1:0]            b_din;
  logic [SEL_W-1:0]            sel_q;
  logic [NA_W-1:0]             nib_q;

  cs_wr_steer #(.ROWS(ROWS), .SUB_W(SUB_W), .NSUB(NSUB), .NIB_W(NIB_W)) u_wr (
    .spare_sel (spare_sel),
    .fill_we   (fill_we),
    .fill_row  (fill_row),
    .fill_wdata(fill_wdata),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .a_we      (a_we),
    .a_din     (a_din),
    .b_we      (b_we),
    .b_din     (b_din)
  );

  for (genvar p = 0; p < NPHYS; p++) begin : g_sub
    cs_subblock #(.ROWS(ROWS), .SUB_W(SUB_W), .NIB_W(NIB_W)) u_sub (
      .clk  (clk),
      .rst  (rst),
      .a_row(fill_row),
      .a_we (a_we[p]),
      .a_din(a_din[p]),
      .b_row(cpu_addr[NA_W +: RA_W]),
      .b_we (b_we[p]),
      .b_din(b_din),
      .a_q  (a_q[p]),
      .b_q  (b_q[p])
    );
  end

  // read-side steering follows the address cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      nib_q <= '0;
    end else begin
      sel_q <= spare_sel;
      nib_q <= cpu_addr[NA_W-1:0];
    end
  end

  cs_rd_steer #(.SUB_W(SUB_W), .NSUB(NSUB), .NIB_W(NIB_W)) u_rd (
    .sel_q     (sel_q),
    .nib_q     (nib_q),
    .a_q       (a_q),
    .b_q       (b_q),
    .fill_rdata(fill_rdata),
    .cpu_rdata (cpu_rdata)
  );
endmodule

// File: rtl/cs_slice_chk.sv
module cs_slice_chk #(
  parameter int ROWS  = 32,
  parameter int SUB_W = 8,
  parameter int NSUB  = 8,
  parameter int NIB_W = 4,
  localparam int RA_W  = $clog2(ROWS),
  localparam int ROW_W = SUB_W * NSUB,
  localparam int NNIB  = ROW_W / NIB_W,
  localparam int NA_W  = $clog2(NNIB),
  localparam int SEL_W = $clog2(NSUB)
) (
  input logic                 clk,
  input logic                 rst,
  input logic [SEL_W-1:0]     spare_sel,
  input logic [RA_W-1:0]      fill_row,
  input logic                 fill_we,
  input logic [ROW_W-1:0]     fill_wdata,
  input logic [ROW_W-1:0]     fill_rdata,
  input logic [RA_W+NA_W-1:0] cpu_addr,
  input logic                 cpu_we,
  input logic [NIB_W-1:0]     cpu_wdata,
  input logic [NIB_W-1:0]     cpu_rdata
);
  logic                 w_we1, c_we1;
  logic [RA_W-1:0]      w_row1;
  logic [ROW_W-1:0]     w_dat1;
  logic [RA_W+NA_W-1:0] c_addr1;
  logic [NIB_W-1:0]     c_dat1;
  logic [SEL_W-1:0]     sel1;
  logic [NIB_W-1:0]     exp_w;
  logic                 rst_seen = 1'b0;
  logic                 quiet, same_sel;

  always_ff @(posedge clk) begin
    rst_seen <= rst_seen | rst;
    if (rst) begin
      w_we1 <= 1'b0; c_we1 <= 1'b0; w_row1 <= '0; w_dat1 <= '0;
      c_addr1 <= '0; c_dat1 <= '0; sel1 <= '0;
    end else begin
      w_we1 <= fill_we; c_we1 <= cpu_we; w_row1 <= fill_row; w_dat1 <= fill_wdata;
      c_addr1 <= cpu_addr; c_dat1 <= cpu_wdata; sel1 <= spare_sel;
    end
  end

  // nibble of last cycle's refill data at the current processor nibble index
  always_comb begin
    exp_w = '0;
    for (int n = 0; n < NNIB; n++) begin
      if (cpu_addr[NA_W-1:0] == NA_W'(n)) exp_w = w_dat1[n*NIB_W +: NIB_W];
    end
  end

  assign quiet    = !fill_we && !cpu_we;
  assign same_sel = (spare_sel == sel1);

  p_fill_rdback_r1: assert property (@(posedge clk) disable iff (rst)
    (w_we1 && fill_row == w_row1 && quiet && same_sel) |=> (fill_rdata == $past(w_dat1)));

  p_nib_pick_r3: assert property (@(posedge clk) disable iff (rst)
    (w_we1 && cpu_addr[NA_W +: RA_W] == w_row1 && quiet && same_sel)
      |=> (cpu_rdata == $past(exp_w)));

  p_nib_write_r4: assert property (@(posedge clk) disable iff (rst)
    (c_we1 && !(w_we1 && w_row1 == c_addr1[NA_W +: RA_W]) && cpu_addr == c_addr1 &&
     quiet && same_sel) |=> (cpu_rdata == $past(c_dat1)));

  p_fill_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (w_we1 && c_we1 && c_addr1[NA_W +: RA_W] == w_row1 && cpu_addr == c_addr1 &&
     quiet && same_sel) |=> (cpu_rdata == $past(exp_w)));

  p_reset_clear_r8: assert property (@(posedge clk)
    (rst_seen && $past(rst)) |-> (fill_rdata == '0 && cpu_rdata == '0));
endmodule

bind cache_slice_spare cs_slice_chk #(
  .ROWS(ROWS), .SUB_W(SUB_W), .NSUB(NSUB), .NIB_W(NIB_W)
) u_chk (
  .clk(clk), .rst(rst), .spare_sel(spare_sel), .fill_row(fill_row),
  .fill_we(fill_we), .fill_wdata(fill_wdata), .fill_rdata(fill_rdata),
  .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
);

// File: tb/cache_slice_spare_tb_top.sv
module cache_slice_spare_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  spare_sel;
  logic [4:0]  fill_row;
  logic        fill_we;
  logic [63:0] fill_wdata;
  logic [63:0] fill_rdata;
  logic [8:0]  cpu_addr;
  logic        cpu_we;
  logic [3:0]  cpu_wdata;
  logic [3:0]  cpu_rdata;

  always #4 clk = ~clk;

  cache_slice_spare dut_i (
    .clk(clk), .rst(rst), .spare_sel(spare_sel), .fill_row(fill_row),
    .fill_we(fill_we), .fill_wdata(fill_wdata), .fill_rdata(fill_rdata),
    .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
  );

  typedef struct {
    bit          is_cpu;
    logic [63:0] exp;
    int          due;
    string       tag;
  } item_t;

  item_t       sb[$];
  int          cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;
  int          cur_sel = 0;
  logic [7:0]  phys [9][32];

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- reference model of the nine physical blocks -------------
  function automatic int pmap(input int l);
    return (l == cur_sel) ? 8 : l;
  endfunction

  function automatic logic [63:0] model_row(input int r);
    logic [63:0] v;
    for (int l = 0; l < 8; l++) v[l*8 +: 8] = phys[pmap(l)][r];
    return v;
  endfunction

  function automatic logic [63:0] pat(input int r, input int s);
    logic [31:0] a, b;
    a = 32'(r) * 32'h9E37_79B1 ^ 32'(s) * 32'h7F4A_7C15;
    b = {a[15:0], a[31:16]} ^ 32'hC3A5_5A3C ^ 32'(s * 7 + r);
    return {a, b};
  endfunction

  // ---------------- driver: one cycle of stimulus, expectations queued -----
  task automatic step(input bit fwe, input int frow, input logic [63:0] fdat,
                      input bit cwe, input int caddr, input logic [3:0] cdat,
                      input bit chk_f, input bit chk_c, input string tag);
    item_t it;
    int crow, cnib, l, h;
    logic [63:0] cur;
    crow = caddr / 16;
    cnib = caddr % 16;
    fill_we = fwe; fill_row = 5'(frow); fill_wdata = fdat;
    cpu_we = cwe; cpu_addr = 9'(caddr); cpu_wdata = cdat;
    if (chk_f) begin
      it.is_cpu = 1'b0; it.exp = model_row(frow); it.due = cyc + 1; it.tag = tag;
      sb.push_back(it);
    end
    if (chk_c) begin
      cur = model_row(crow);
      it.is_cpu = 1'b1; it.exp = {60'd0, cur[cnib*4 +: 4]}; it.due = cyc + 1; it.tag = tag;
      sb.push_back(it);
    end
    if (cwe && !(fwe && frow == crow)) begin
      l = cnib / 2; h = cnib % 2;
      phys[pmap(l)][crow][h*4 +: 4] = cdat;
    end
    if (fwe) for (int k = 0; k < 8; k++) phys[pmap(k)][frow] = fdat[k*8 +: 8];
    @(negedge clk);
  endtask

  task automatic idle();
    step(1'b0, 0, 64'd0, 1'b0, 0, 4'd0, 1'b0, 1'b0, "");
  endtask

  task automatic set_sel(input int k);
    spare_sel = 3'(k);
    cur_sel = k;
    idle();
  endtask

  // ---------------- monitor: pops and compares due results ------------------
  always @(posedge clk) begin
    cyc++;
    #2;
    while (sb.size() > 0 && sb[0].due == cyc) begin
      item_t it;
      it = sb.pop_front();
      if (it.is_cpu) check({60'd0, cpu_rdata}, it.exp, it.tag);
      else           check(fill_rdata, it.exp, it.tag);
    end
  end

  // ---------------- watchdog ------------------------------------------------
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ------------------------------------------------
  initial begin
    rst = 1'b1; spare_sel = 3'd0; fill_row = '0; fill_we = 1'b0; fill_wdata = '0;
    cpu_addr = '0; cpu_we = 1'b0; cpu_wdata = '0;
    repeat (2) @(posedge clk);
    #2;
    check(fill_rdata, 64'd0, "R8 reset fill_rdata");
    check({60'd0, cpu_rdata}, 64'd0, "R8 reset cpu_rdata");
    @(negedge clk);
    rst = 1'b0;

    // initialise all nine physical blocks
    set_sel(0);
    for (int r = 0; r < 32; r++) step(1'b1, r, pat(r, 1), 1'b0, 0, 4'd0, 1'b0, 1'b0, "");
    set_sel(1);
    for (int r = 0; r < 32; r++) step(1'b1, r, pat(r, 2), 1'b0, 0, 4'd0, 1'b0, 1'b0, "");

    // R1 / R2: full-row write and read-back under spare_sel=3
    set_sel(3);
    for (int r = 0; r < 32; r++) step(1'b1, r, pat(r, 3), 1'b0, 0, 4'd0, 1'b0, 1'b0, "");
    for (int r = 0; r < 32; r++)
      step(1'b0, r, 64'd0, 1'b0, r*16 + (r % 16), 4'd0, 1'b1, 1'b1, "R1 row read-back");
    // R2: read of a row as it is written returns the old contents
    step(1'b1, 7, pat(7, 4), 1'b0, 0, 4'd0, 1'b1, 1'b0, "R2 read-first");
    step(1'b0, 7, 64'd0, 1'b0, 0, 4'd0, 1'b1, 1'b0, "R2 new data next cycle");

    // R3: every nibble of one row
    for (int n = 0; n < 16; n++)
      step(1'b0, 0, 64'd0, 1'b0, 5*16 + n, 4'd0, 1'b0, 1'b1, "R3 nibble select");

    // R4: narrow writes touch only their nibble
    for (int n = 0; n < 16; n++) begin
      step(1'b0, 0, 64'd0, 1'b1, 9*16 + n, 4'(n ^ 4'hA), 1'b0, 1'b0, "");
      step(1'b0, 9, 64'd0, 1'b0, 9*16 + n, 4'd0, 1'b1, 1'b1, "R4 nibble write isolation");
    end

    // R5: same-row conflict and different-row concurrency
    step(1'b1, 12, pat(12, 5), 1'b1, 12*16 + 6, 4'hF, 1'b0, 1'b0, "");
    step(1'b0, 12, 64'd0, 1'b0, 12*16 + 6, 4'd0, 1'b1, 1'b1, "R5 refill wins same row");
    step(1'b1, 13, pat(13, 5), 1'b1, 14*16 + 6, 4'h5, 1'b0, 1'b0, "");
    step(1'b0, 13, 64'd0, 1'b0, 14*16 + 6, 4'd0, 1'b1, 1'b1, "R5 both writes differ rows");
    step(1'b0, 14, 64'd0, 1'b0, 0, 4'd0, 1'b1, 1'b0, "R5 narrow row intact");

    // R6 / R7: sweep every retired sub-block with corrupt contents in it
    for (int k = 0; k < 8; k++) begin
      set_sel((k + 1) % 8);
      for (int r = 0; r < 32; r++) step(1'b1, r, ~pat(r, 40 + k), 1'b0, 0, 4'd0, 1'b0, 1'b0, "");
      set_sel(k);
      for (int r = 0; r < 32; r++) step(1'b1, r, pat(r, 60 + k), 1'b0, 0, 4'd0, 1'b0, 1'b0, "");
      for (int r = 0; r < 4; r++)
        step(1'b0, 0, 64'd0, 1'b1, r*16 + 2*k + (r % 2), 4'(r + k), 1'b0, 1'b0, "");
      for (int r = 0; r < 32; r++) begin
        step(1'b0, r, 64'd0, 1'b0, r*16 + 2*k, 4'd0, 1'b1, 1'b1, "R6 spare row integrity");
        step(1'b0, r, 64'd0, 1'b0, r*16 + 2*k + 1, 4'd0, 1'b0, 1'b1, "R6 spare upper nibble");
      end
      set_sel((k + 1) % 8);
      for (int r = 0; r < 32; r++)
        step(1'b0, r, 64'd0, 1'b0, 0, 4'd0, 1'b1, 1'b0, "R7 remap without data move");
    end

    // R8: reset mid-run clears outputs, keeps rows
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #2;
    check(fill_rdata, 64'd0, "R8 mid-run reset fill_rdata");
    check({60'd0, cpu_rdata}, 64'd0, "R8 mid-run reset cpu_rdata");
    @(negedge clk);
    rst = 1'b0;
    spare_sel = 3'(cur_sel);
    for (int r = 0; r < 32; r += 5)
      step(1'b0, r, 64'd0, 1'b0, r*16 + 3, 4'd0, 1'b1, 1'b1, "R8 rows kept over reset");

    repeat (3) idle();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule